// File: doc/BRIEF.md
# Transactional SIMT Reconvergence Stack

This block tracks control flow for one warp of four scalar threads that share a single program counter and run in lockstep. A stack of entries, each holding a PC, a reconvergence PC, a retry PC, an active mask and a type bit, records where diverged thread groups must meet again. The entry on top supplies the warp's current PC and active mask. An issue pulse tells the block which kind of instruction the warp has just executed: plain, branch, transaction begin or transaction commit. The block then advances the stack.

A hardware transaction is treated as a loop. Transaction begin parks the enclosing entry at the instruction after the commit and pushes a transaction entry that remembers the begin PC. At commit, the threads whose validation failed are gathered into a retry mask. If any thread failed, the warp jumps back to the begin PC with only the failed threads active. The threads that committed stay masked off below and rejoin only when the whole warp has committed. Branches inside the transaction nest above the transaction entry and reconverge before the commit. Register checkpointing, fetch and memory are not part of this block.

Top module: `tmstk_core`

## Requirements
- R1: After reset, pc equals the START_PC parameter (default 0), active_mask is 4'b1111 and stack_overflow is 0.
- R2: A plain instruction (issue with no operation flag) moves pc to pc+1 and keeps the mask. A cycle without issue changes neither pc nor active_mask.
- R3: A branch whose taken bits, ANDed with the active mask, are all active threads moves pc to br_target. If no active thread takes it, pc moves to pc+1. In both cases the mask is unchanged and nothing is pushed.
- R4: A divergent branch runs the taken threads first, at br_target with the mask (br_taken & active). When that path's next PC equals br_reconv, the not-taken threads run from pc+1. When they also reach br_reconv, the original mask resumes at br_reconv.
- R5: Transaction begin moves pc to pc+1 with the same mask and clears the retry mask. The later commit uses tx_exit_pc as the point where the warp reconverges.
- R6: A commit on a transaction entry with no failing thread pops the entry. pc becomes tx_exit_pc and the mask returns to the mask held before the begin.
- R7: A commit on a transaction entry where (tx_abort & active_mask) is non-zero moves pc to the begin PC with only those threads active. Abort bits of inactive threads are ignored.
- R8: Transaction begin executed at the begin PC of the transaction entry on top (a retry) pushes nothing. It moves pc to pc+1 with the retrying mask and clears the retry mask.
- R9: A divergent branch inside a transaction nests above the transaction entry. After both paths reconverge, the full transaction mask resumes before the commit.
- R10: A begin or divergent branch that needs more free slots than remain in the 8-entry stack leaves pc and active_mask unchanged and sets stack_overflow. The flag stays set until reset.
- R11: A commit while the top entry is not a transaction entry acts as a plain instruction.
- R12: For a divergent branch, a path whose start PC equals br_reconv gets no stack slot. A branch that needs only one free slot still proceeds when exactly one slot is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | The instruction at pc was executed this cycle |
| is_branch | input | 1 | Issued instruction is a conditional branch |
| br_taken | input | 4 | Per-thread branch outcome |
| br_target | input | 16 | Branch target PC |
| br_reconv | input | 16 | Branch reconvergence PC |
| is_tx_begin | input | 1 | Issued instruction is transaction begin |
| tx_exit_pc | input | 16 | PC of the instruction after the matching commit |
| is_tx_commit | input | 1 | Issued instruction is transaction commit |
| tx_abort | input | 4 | Per-thread validation failure at commit |
| pc | output | 16 | Next PC of the warp |
| active_mask | output | 4 | Threads enabled at pc |
| stack_overflow | output | 1 | Sticky stack-full error |

## Verification
Two functions can meet in one cycle: a divergence push and the depth limit. Whether the push fits depends on the rule that drops a path starting at its reconvergence point. The bench fills the stack to seven entries with nested transaction begins. It then issues a branch whose taken path starts at br_reconv; this one-slot push must go through without the flag. A second divergent branch needing two slots must then freeze pc and mask and raise the flag. A similar coincidence appears at commit, where abort bits of masked-off threads arrive together with real failures. Only the active failures may end up in the retry mask.

// File: rtl/tmstk_pkg.sv
// Shared widths and the stack entry layout for the transactional SIMT stack.
package tmstk_pkg;
    parameter int TM_WARP = 4;   // scalar threads per warp
    parameter int TM_PCW  = 16;  // program counter width

    // One reconvergence stack entry
    typedef struct packed {
        logic [TM_PCW-1:0]  pc;        // next PC of this thread group
        logic [TM_PCW-1:0]  rpc;       // PC where the group pops
        logic [TM_PCW-1:0]  retry_pc;  // begin PC (transaction entries only)
        logic [TM_WARP-1:0] mask;      // threads of this group
        logic               is_tx;     // 1: transaction retry entry
    } stk_ent_t;
endpackage

// File: rtl/tmstk_store.sv
// Register storage for the stack. Accepts a rewrite of the top slot, up to two
// pushes, or a pop each cycle. Assumes the controller never asks for an
// illegal mix (push and pop together, push past DEPTH, pop of the bottom).
module tmstk_store
    import tmstk_pkg::*;
#(
    parameter int                DEPTH    = 8,
    parameter logic [TM_PCW-1:0] START_PC = '0,
    localparam int DW = $clog2(DEPTH + 1),
    localparam int AW = $clog2(DEPTH),
    localparam int EW = $bits(stk_ent_t)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          top_we,
    input  stk_ent_t      top_wdata,
    input  logic [1:0]    push_n,
    input  stk_ent_t      push_lo,
    input  stk_ent_t      push_hi,
    input  logic          pop,
    output stk_ent_t      top_ent,
    output logic [DW-1:0] depth
);

    logic [DEPTH*EW-1:0] flat;
    logic [AW-1:0]       top_idx;
    stk_ent_t            base_ent;

    assign base_ent = '{pc: START_PC, rpc: '1, retry_pc: '0, mask: '1, is_tx: 1'b0};
    assign top_idx  = AW'(depth - 1'b1);

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            stk_ent_t ent_q;
            // Slot g: load base on reset, then take a push or a top rewrite
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_q <= (g == 0) ? base_ent : '0;
                end else if (push_n != 2'd0 && DW'(g) == depth) begin
                    ent_q <= push_lo;
                end else if (push_n == 2'd2 && DW'(g) == depth + 1'b1) begin
                    ent_q <= push_hi;
                end else if (top_we && DW'(g) == depth - 1'b1) begin
                    ent_q <= top_wdata;
                end
            end
            assign flat[g*EW +: EW] = ent_q;
        end
    endgenerate

    // Occupancy: one entry after reset, then pushes minus pops
    always_ff @(posedge clk) begin
        if (!rst_n) depth <= DW'(1);
        else        depth <= depth + DW'(push_n) - DW'(pop);
    end

    assign top_ent = flat[top_idx*EW +: EW];

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        depth >= DW'(1) && depth <= DW'(DEPTH)); // R10

endmodule

// File: rtl/tmstk_ctrl.sv
// Combinational next-state decision for one issued instruction. Priority is
// commit, retry-begin, begin, divergent branch, then uniform/plain flow.
// Assumes at most one operation flag is meaningful per issue.
module tmstk_ctrl
    import tmstk_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int DW = $clog2(DEPTH + 1)
) (
    input  stk_ent_t           top_ent,
    input  logic [DW-1:0]      depth,
    input  logic [TM_WARP-1:0] retry_q,
    input  logic               issue,
    input  logic               is_branch,
    input  logic [TM_WARP-1:0] br_taken,
    input  logic [TM_PCW-1:0]  br_target,
    input  logic [TM_PCW-1:0]  br_reconv,
    input  logic               is_tx_begin,
    input  logic [TM_PCW-1:0]  tx_exit_pc,
    input  logic               is_tx_commit,
    input  logic [TM_WARP-1:0] tx_abort,
    output logic               top_we,
    output stk_ent_t           top_wdata,
    output logic [1:0]         push_n,
    output stk_ent_t           push_lo,
    output stk_ent_t           push_hi,
    output logic               pop,
    output logic [TM_WARP-1:0] retry_d,
    output logic               ovf_set
);

    logic [TM_PCW-1:0]  seq_pc, flow_pc;
    logic [TM_WARP-1:0] taken_act, fail_mask;
    logic               commit_act, rebegin, diverge, want_t, want_nt, can_pop;
    logic [DW-1:0]      room, need;
    stk_ent_t           ent_t, ent_nt;

    // Derived conditions of the issued instruction against the top entry
    always_comb begin
        seq_pc     = top_ent.pc + 1'b1;
        taken_act  = br_taken & top_ent.mask;
        fail_mask  = retry_q | (tx_abort & top_ent.mask);
        commit_act = is_tx_commit && top_ent.is_tx;
        rebegin    = is_tx_begin && top_ent.is_tx && (top_ent.retry_pc == top_ent.pc);
        diverge    = is_branch && (taken_act != '0) && (taken_act != top_ent.mask);
        want_t     = (br_target != br_reconv);
        want_nt    = (seq_pc != br_reconv);
        need       = DW'(want_t) + DW'(want_nt);
        room       = DW'(DEPTH) - depth;
        can_pop    = (depth > DW'(1)) && !top_ent.is_tx;
        flow_pc    = (is_branch && taken_act != '0) ? br_target : seq_pc;
        ent_t      = '{pc: br_target, rpc: br_reconv, retry_pc: '0, mask: taken_act, is_tx: 1'b0};
        ent_nt     = '{pc: seq_pc, rpc: br_reconv, retry_pc: '0,
                       mask: top_ent.mask & ~taken_act, is_tx: 1'b0};
    end

    // Stack command selection
    always_comb begin
        top_we    = 1'b0;
        top_wdata = top_ent;
        push_n    = 2'd0;
        push_lo   = '0;
        push_hi   = '0;
        pop       = 1'b0;
        retry_d   = retry_q;
        ovf_set   = 1'b0;
        if (issue) begin
            if (commit_act) begin
                if (fail_mask != '0) begin
                    top_we             = 1'b1;
                    top_wdata.pc       = top_ent.retry_pc;
                    top_wdata.mask     = fail_mask;
                    retry_d            = fail_mask;
                end else begin
                    pop     = 1'b1;
                    retry_d = '0;
                end
            end else if (rebegin) begin
                top_we       = 1'b1;
                top_wdata.pc = seq_pc;
                retry_d      = '0;
            end else if (is_tx_begin) begin
                if (room >= DW'(1)) begin
                    top_we       = 1'b1;
                    top_wdata.pc = tx_exit_pc;
                    push_n       = 2'd1;
                    push_lo      = '{pc: seq_pc, rpc: tx_exit_pc, retry_pc: top_ent.pc,
                                     mask: top_ent.mask, is_tx: 1'b1};
                    retry_d      = '0;
                end else begin
                    ovf_set = 1'b1;
                end
            end else if (diverge) begin
                if (room >= need) begin
                    top_we       = 1'b1;
                    top_wdata.pc = br_reconv;
                    push_n       = need[1:0];
                    if (want_nt) begin
                        push_lo = ent_nt;
                        push_hi = ent_t;
                    end else begin
                        push_lo = ent_t;
                    end
                end else begin
                    ovf_set = 1'b1;
                end
            end else if (can_pop && flow_pc == top_ent.rpc) begin
                pop = 1'b1;
            end else begin
                top_we       = 1'b1;
                top_wdata.pc = flow_pc;
            end
        end
    end

endmodule

// File: rtl/tmstk_core.sv
// Top of the transactional SIMT reconvergence stack for one warp. Holds the
// retry mask and the sticky overflow flag; pc and active_mask come straight
// from the top stack entry. Assumes inputs are valid only with issue high.
module tmstk_core
    import tmstk_pkg::*;
#(
    parameter int                DEPTH    = 8,
    parameter logic [TM_PCW-1:0] START_PC = '0,
    localparam int DW = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic               is_branch,
    input  logic [TM_WARP-1:0] br_taken,
    input  logic [TM_PCW-1:0]  br_target,
    input  logic [TM_PCW-1:0]  br_reconv,
    input  logic               is_tx_begin,
    input  logic [TM_PCW-1:0]  tx_exit_pc,
    input  logic               is_tx_commit,
    input  logic [TM_WARP-1:0] tx_abort,
    output logic [TM_PCW-1:0]  pc,
    output logic [TM_WARP-1:0] active_mask,
    output logic               stack_overflow
);

    stk_ent_t           top_ent, top_wdata, push_lo, push_hi;
    logic               top_we, pop, ovf_set;
    logic [1:0]         push_n;
    logic [DW-1:0]      depth;
    logic [TM_WARP-1:0] retry_q, retry_d;

    tmstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .top_ent(top_ent), .depth(depth), .retry_q(retry_q), .issue(issue),
        .is_branch(is_branch), .br_taken(br_taken), .br_target(br_target),
        .br_reconv(br_reconv), .is_tx_begin(is_tx_begin), .tx_exit_pc(tx_exit_pc),
        .is_tx_commit(is_tx_commit), .tx_abort(tx_abort), .top_we(top_we),
        .top_wdata(top_wdata), .push_n(push_n), .push_lo(push_lo), .push_hi(push_hi),
        .pop(pop), .retry_d(retry_d), .ovf_set(ovf_set)
    );

    tmstk_store #(.DEPTH(DEPTH), .START_PC(START_PC)) u_store (
        .clk(clk), .rst_n(rst_n), .top_we(top_we), .top_wdata(top_wdata),
        .push_n(push_n), .push_lo(push_lo), .push_hi(push_hi), .pop(pop),
        .top_ent(top_ent), .depth(depth)
    );

    // Retry mask and sticky overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_q        <= '0;
            stack_overflow <= 1'b0;
        end else begin
            retry_q        <= retry_d;
            stack_overflow <= stack_overflow | ovf_set;
        end
    end

    assign pc          = top_ent.pc;
    assign active_mask = top_ent.mask;

    AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(pc) && $stable(active_mask)); // R2
    AST_RETRY_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_tx_commit && top_ent.is_tx && (tx_abort & active_mask) != '0)
        |=> (pc == $past(top_ent.retry_pc)) && ((active_mask & ~$past(active_mask)) == '0)); // R7
    AST_COMMIT_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_tx_commit && top_ent.is_tx && retry_q == '0 && (tx_abort & active_mask) == '0)
        |=> depth == $past(depth) - 1'b1); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stack_overflow |=> stack_overflow); // R10
    AST_OVF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> $stable(pc) && $stable(active_mask) && stack_overflow); // R10

endmodule

// File: tb/tmstk_core_test.sv
`timescale 1ns/1ps
module tmstk_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0, is_branch = 1'b0, is_tx_begin = 1'b0, is_tx_commit = 1'b0;
    logic [3:0]  br_taken = '0, tx_abort = '0;
    logic [15:0] br_target = '0, br_reconv = '0, tx_exit_pc = '0;
    logic [15:0] pc;
    logic [3:0]  active_mask;
    logic        stack_overflow;
    int          total = 0, bad = 0, cycles = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    tmstk_core uut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .is_branch(is_branch),
        .br_taken(br_taken), .br_target(br_target), .br_reconv(br_reconv),
        .is_tx_begin(is_tx_begin), .tx_exit_pc(tx_exit_pc),
        .is_tx_commit(is_tx_commit), .tx_abort(tx_abort),
        .pc(pc), .active_mask(active_mask), .stack_overflow(stack_overflow)
    );

    // op: 0 idle, 1 plain, 2 branch, 3 tx begin, 4 tx commit
    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [3:0]  bits;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] epc;
        logic [3:0]  emask;
    } row_t;

    localparam int NROW = 22;
    localparam row_t TBL [NROW] = '{
        '{4'd2,  3'd1, 4'b0000, 16'd0,  16'd0, 16'd1,  4'b1111}, // R2 plain
        '{4'd4,  3'd2, 4'b0101, 16'd5,  16'd8, 16'd5,  4'b0101}, // R4 diverge, taken first
        '{4'd2,  3'd1, 4'b0000, 16'd0,  16'd0, 16'd6,  4'b0101}, // R2
        '{4'd2,  3'd1, 4'b0000, 16'd0,  16'd0, 16'd7,  4'b0101}, // R2
        '{4'd4,  3'd1, 4'b0000, 16'd0,  16'd0, 16'd2,  4'b1010}, // R4 not-taken path
        '{4'd3,  3'd2, 4'b1111, 16'd7,  16'd8, 16'd7,  4'b1010}, // R3 uniform taken
        '{4'd4,  3'd1, 4'b0000, 16'd0,  16'd0, 16'd8,  4'b1111}, // R4 reconverged
        '{4'd3,  3'd2, 4'b0000, 16'd20, 16'd30,16'd9,  4'b1111}, // R3 uniform not taken
        '{4'd5,  3'd3, 4'b0000, 16'd16, 16'd0, 16'd10, 4'b1111}, // R5 begin
        '{4'd9,  3'd2, 4'b0011, 16'd12, 16'd13,16'd12, 4'b0011}, // R9 nested diverge
        '{4'd9,  3'd1, 4'b0000, 16'd0,  16'd0, 16'd11, 4'b1100}, // R9
        '{4'd9,  3'd1, 4'b0000, 16'd0,  16'd0, 16'd12, 4'b1100}, // R9
        '{4'd9,  3'd1, 4'b0000, 16'd0,  16'd0, 16'd13, 4'b1111}, // R9 back to tx mask
        '{4'd2,  3'd1, 4'b0000, 16'd0,  16'd0, 16'd14, 4'b1111}, // R2
        '{4'd7,  3'd4, 4'b0110, 16'd0,  16'd0, 16'd9,  4'b0110}, // R7 retry
        '{4'd8,  3'd3, 4'b0000, 16'd16, 16'd0, 16'd10, 4'b0110}, // R8 re-begin
        '{4'd2,  3'd1, 4'b0000, 16'd0,  16'd0, 16'd11, 4'b0110}, // R2
        '{4'd7,  3'd4, 4'b1111, 16'd0,  16'd0, 16'd9,  4'b0110}, // R7 inactive aborts ignored
        '{4'd8,  3'd3, 4'b0000, 16'd16, 16'd0, 16'd10, 4'b0110}, // R8
        '{4'd6,  3'd4, 4'b1000, 16'd0,  16'd0, 16'd16, 4'b1111}, // R6 all committed
        '{4'd11, 3'd4, 4'b1111, 16'd0,  16'd0, 16'd17, 4'b1111}, // R11 commit outside tx
        '{4'd2,  3'd0, 4'b0000, 16'd0,  16'd0, 16'd17, 4'b1111}  // R2 idle
    };

    task automatic chk(input string tag, input logic [15:0] ep, input logic [3:0] em,
                       input logic eo);
        total++;
        if (pc !== ep || active_mask !== em || stack_overflow !== eo) begin
            bad++;
            $display("FAIL %s: pc=%0d mask=%b ovf=%b expected pc=%0d mask=%b ovf=%b",
                     tag, pc, active_mask, stack_overflow, ep, em, eo);
        end
    endtask

    // Drive one instruction at a negedge, let it register, return at next negedge
    task automatic step(input logic [2:0] op, input logic [3:0] bits,
                        input logic [15:0] a, input logic [15:0] b);
        issue        = (op != 3'd0);
        is_branch    = (op == 3'd2);
        is_tx_begin  = (op == 3'd3);
        is_tx_commit = (op == 3'd4);
        br_taken     = bits;
        tx_abort     = bits;
        br_target    = a;
        tx_exit_pc   = a;
        br_reconv    = b;
        @(posedge clk);
        @(negedge clk);
        issue = 1'b0; is_branch = 1'b0; is_tx_begin = 1'b0; is_tx_commit = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            finish_run();
        end
    end

    initial begin
        do_reset();
        chk("R1 reset state", 16'd0, 4'b1111, 1'b0);

        for (int i = 0; i < NROW; i++) begin
            step(TBL[i].op, TBL[i].bits, TBL[i].a, TBL[i].b);
            chk($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].epc, TBL[i].emask, 1'b0);
        end

        // R1: reset in the middle of activity
        step(3'd2, 4'b0011, 16'd40, 16'd50);
        do_reset();
        chk("R1 reset after activity", 16'd0, 4'b1111, 1'b0);

        // R12: taken path starts at the reconvergence PC, no slot for it
        step(3'd2, 4'b0011, 16'd4, 16'd4);
        chk("R12 only not-taken path runs", 16'd1, 4'b1100, 1'b0);
        step(3'd1, 4'b0000, 16'd0, 16'd0);
        step(3'd1, 4'b0000, 16'd0, 16'd0);
        step(3'd1, 4'b0000, 16'd0, 16'd0);
        chk("R12 reconverged", 16'd4, 4'b1111, 1'b0);

        // R10 / R12: fill to seven entries, one-slot divergence fits, two-slot does not
        do_reset();
        for (int k = 0; k < 6; k++) step(3'd3, 4'b0000, 16'd100, 16'd0);
        chk("R5 nested begins", 16'd6, 4'b1111, 1'b0);
        step(3'd2, 4'b0011, 16'd9, 16'd9);
        chk("R12 one-slot push at last slot", 16'd7, 4'b1100, 1'b0);
        step(3'd2, 4'b0100, 16'd20, 16'd30);
        chk("R10 overflow freezes state", 16'd7, 4'b1100, 1'b1);
        step(3'd1, 4'b0000, 16'd0, 16'd0);
        chk("R10 flag sticky", 16'd8, 4'b1100, 1'b1);
        step(3'd3, 4'b0000, 16'd100, 16'd0);
        chk("R10 begin on full stack", 16'd8, 4'b1100, 1'b1);
        do_reset();
        chk("R10 reset clears flag", 16'd0, 4'b1111, 1'b0);

        finish_run();
    end

endmodule